// File: doc/BRIEF.md
# Dual-Select Asynchronous Static RAM Core

This block models a byte-wide asynchronous static RAM so that it can be synthesized. Two chip selects of opposite polarity, an output enable and a write enable, all active low except the second select, are decoded into four modes: idle, output off, read and write. The bidirectional data bus is split into a write-data input, a read-data output and a drive-enable output. A pad ring or a board model recombines them into a three-state bus.

A fast free-running clock samples every control, address and data pin once per cycle. All behaviour is defined on those samples. A write exists only while the device is selected and the write enable is low. It starts with whichever of the three conditions becomes true last and ends with whichever becomes false first. The word in the array changes only when the write ends. It takes the address and data held in the final sample inside the write.

The depth is set by `ADDR_W`. The default of 11 address bits (2048 words) keeps elaboration small. Setting `ADDR_W` to 17 gives the full 128K x 8 organization on address bits 0 to 16. Sampled control or address bits that are X or Z are treated as a deselect.

Top module: `sram_dual_sel`

## Requirements
- R1: While `rst_n` is low, and in the sample right after its release unless a read is sampled, `dout_en` is 0.
- R2: When the sample holds `cs1_n` = 1, `dout_en` is 0 and no array word changes, whatever `oe_n` and `we_n` are.
- R3: When the sample holds `cs2` = 0, `dout_en` is 0 and no array word changes, whatever `oe_n` and `we_n` are.
- R4: Selected (`cs1_n`=0, `cs2`=1) with `we_n`=1 and `oe_n`=1 gives the output-off mode: `dout_en` is 0 and nothing is written.
- R5: Selected with `we_n`=1 and `oe_n`=0 is a read. After the clock edge that samples it, `dout_en` is 1 and `dout` equals the word at the sampled `addr`.
- R6: Selected with `we_n`=0 is a write whatever `oe_n` is. `dout_en` is 0 after the same edge that samples the last of the three write conditions becoming true.
- R7: A write updates the array only at its end. The stored word and address are those sampled in the last cycle of the write, so earlier data in the same write does not land.
- R8: A write ends, and commits, when any one of these is sampled: `we_n` rising, `cs1_n` rising or `cs2` falling.
- R9: A read sampled on the same edge that ends a write to the same address returns the newly written word.
- R10: Every address from 0 to 2^`ADDR_W`-1 is distinct and usable, including the top address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sample stage |
| cs1_n | input | 1 | Active-low chip select |
| cs2 | input | 1 | Active-high chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data from the bus |
| dout | output | DATA_W | Read data toward the bus |
| dout_en | output | 1 | Bus drive enable, 1 only in read mode |

## Verification
The bench lets `oe_n` fall low during a write. A design that let the output enable win would drive the bus against the incoming data. It changes `din` in the middle of one write and expects only the final value. A design that wrote on every cycle of the overlap would pass that check by luck, so the bench also writes with a select already removed and expects the earlier value to survive, which a design that ignored either select would overwrite. Each of the three end conditions closes one write. A read of the same word on the closing edge catches a commit that lands a cycle late. A write to the top address catches a truncated decoder.

// File: rtl/sram_ds_pkg.sv
package sram_ds_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_HIZ   = 2'd1,
    MODE_READ  = 2'd2,
    MODE_WRITE = 2'd3
  } mode_e;

  // Control truth table; unknown controls count as deselected.
  function automatic mode_e mode_of(input logic known, input logic sel1_n,
                                    input logic sel2, input logic oen,
                                    input logic wen);
    mode_e m;
    if (!known || sel1_n || !sel2) m = MODE_IDLE;
    else if (!wen)                 m = MODE_WRITE;
    else if (!oen)                 m = MODE_READ;
    else                           m = MODE_HIZ;
    return m;
  endfunction

endpackage

// File: rtl/sram_ds_sampler.sv
module sram_ds_sampler
  import sram_ds_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output mode_e             mode_raw,
  output mode_e             mode_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] din_q
);

  logic known_raw;
  assign known_raw = !$isunknown({cs1_n, cs2, oe_n, we_n, addr});
  assign mode_raw  = mode_of(known_raw, cs1_n, cs2, oe_n, we_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_IDLE;
      addr_q <= '0;
      din_q  <= '0;
    end else begin
      mode_q <= mode_raw;
      addr_q <= addr;
      din_q  <= din;
    end
  end

endmodule

// File: rtl/sram_ds_commit.sv
module sram_ds_commit
  import sram_ds_pkg::*;
(
  input  logic  rst_n,
  input  mode_e mode_q,
  input  mode_e mode_raw,
  output logic  commit
);

  // The write closes on the edge whose new sample leaves write mode.
  always_comb begin
    commit = rst_n && (mode_q == MODE_WRITE) && (mode_raw != MODE_WRITE);
  end

endmodule

// File: rtl/sram_ds_array.sv
module sram_ds_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/sram_dual_sel.sv
module sram_dual_sel
  import sram_ds_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  mode_e             mode_raw;
  mode_e             mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] din_q;
  logic              commit;
  logic [DATA_W-1:0] rd_word;

  sram_ds_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_smp (
    .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2(cs2), .oe_n(oe_n),
    .we_n(we_n), .addr(addr), .din(din), .mode_raw(mode_raw),
    .mode_q(mode_q), .addr_q(addr_q), .din_q(din_q)
  );

  sram_ds_commit u_cmt (
    .rst_n(rst_n), .mode_q(mode_q), .mode_raw(mode_raw), .commit(commit)
  );

  sram_ds_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .wr_en(commit), .wr_addr(addr_q), .wr_data(din_q),
    .rd_addr(addr_q), .rd_data(rd_word)
  );

  assign dout_en = (mode_q == MODE_READ);
  assign dout    = dout_en ? rd_word : '0;

endmodule

// File: rtl/sram_dual_sel_chk.sv
module sram_dual_sel_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs1_n,
  input logic              cs2,
  input logic              oe_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en
);

  // R2
  cs1_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs1_n) |-> !dout_en);

  // R3
  cs2_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cs2) |-> !dout_en);

  // R4
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(oe_n) |-> !dout_en);

  // R5
  read_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!cs1_n && cs2 && we_n && !oe_n)) |-> dout_en);

  // R6
  write_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cs1_n && cs2 && !we_n) |-> !dout_en);

  // Unknown control or address pins are flagged.
  ctl_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({cs1_n, cs2, oe_n, we_n, addr}));

endmodule

bind sram_dual_sel sram_dual_sel_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2(cs2), .oe_n(oe_n),
  .we_n(we_n), .addr(addr), .dout(dout), .dout_en(dout_en)
);

// File: tb/sram_dual_sel_tb_top.sv
`timescale 1ns/1ps
module sram_dual_sel_tb_top;

  localparam int AW = 11;
  localparam int DW = 8;
  localparam int NV = 21;
  localparam int VW = 4 + 4 + AW + DW + 1 + DW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs1_n = 1'b1, cs2 = 1'b0, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_en;
  int            n_chk = 0;
  int            n_bad = 0;

  always #2.5 clk = ~clk;

  sram_dual_sel #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2(cs2), .oe_n(oe_n),
    .we_n(we_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  // {req, cs1_n cs2 oe_n we_n, addr, din, exp_en, exp_dout}
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd2, 4'b1001, 11'd0,    8'h00, 1'b0, 8'h00}, // R2 deselected
    {4'd6, 4'b0110, 11'd5,    8'hA5, 1'b0, 8'h00}, // R6 write 5
    {4'd8, 4'b1101, 11'd5,    8'h00, 1'b0, 8'h00}, // R8 cs1 ends write
    {4'd5, 4'b0101, 11'd5,    8'h00, 1'b1, 8'hA5}, // R5 read back
    {4'd6, 4'b0100, 11'd6,    8'h3C, 1'b0, 8'h00}, // R6 oe low ignored
    {4'd7, 4'b0100, 11'd6,    8'hC3, 1'b0, 8'h00}, // R7 data changes
    {4'd4, 4'b0111, 11'd6,    8'h00, 1'b0, 8'h00}, // R4 output off, we ends
    {4'd7, 4'b0101, 11'd6,    8'h00, 1'b1, 8'hC3}, // R7 last data stored
    {4'd3, 4'b0000, 11'd5,    8'hFF, 1'b0, 8'h00}, // R3 cs2 low no write
    {4'd2, 4'b1100, 11'd5,    8'hFF, 1'b0, 8'h00}, // R2 cs1 high no write
    {4'd3, 4'b0101, 11'd5,    8'h00, 1'b1, 8'hA5}, // R3 word intact
    {4'd6, 4'b0110, 11'd7,    8'h11, 1'b0, 8'h00}, // R6 write 7
    {4'd8, 4'b0010, 11'd7,    8'h22, 1'b0, 8'h00}, // R8 cs2 ends write
    {4'd8, 4'b0101, 11'd7,    8'h00, 1'b1, 8'h11}, // R8 read 7
    {4'd5, 4'b0101, 11'd5,    8'h00, 1'b1, 8'hA5}, // R5 read 5
    {4'd6, 4'b0100, 11'd8,    8'h77, 1'b0, 8'h00}, // R6 we asserts last
    {4'd9, 4'b0101, 11'd8,    8'h00, 1'b1, 8'h77}, // R9 read on closing edge
    {4'd10, 4'b0110, 11'd2047, 8'h5A, 1'b0, 8'h00}, // R10 top address write
    {4'd10, 4'b0101, 11'd2047, 8'h00, 1'b1, 8'h5A}, // R10 top address read
    {4'd10, 4'b0101, 11'd6,    8'h00, 1'b1, 8'hC3}, // R10 no aliasing
    {4'd4, 4'b0111, 11'd6,    8'h00, 1'b0, 8'h00}  // R4 output off
  };

  task automatic check(input int req, input logic [DW:0] act,
                       input logic [DW:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: actual en/data %b/%h, expected %b/%h",
               req, act[DW], act[DW-1:0], exp[DW], exp[DW-1:0]);
    end
  endtask

  task automatic drive(input logic [3:0] ctl, input logic [AW-1:0] a,
                       input logic [DW-1:0] d);
    {cs1_n, cs2, oe_n, we_n} = ctl;
    addr = a;
    din  = d;
  endtask

  initial begin : watchdog
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual hung, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    // R1: reset holds the bus off even with a read presented.
    @(negedge clk);
    drive(4'b0101, 11'd0, 8'h00);
    @(negedge clk);
    check(1, {dout_en, 8'h00}, {1'b0, 8'h00});
    @(negedge clk);
    drive(4'b0111, 11'd0, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check(1, {dout_en, 8'h00}, {1'b0, 8'h00}); // R1 after release

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      drive(v[VW-5 -: 4], v[VW-9 -: AW], v[2*DW : DW+1]);
      @(negedge clk);
      check(int'(v[VW-1 -: 4]), {dout_en, dout_en ? dout : 8'h00},
            {v[DW], v[DW-1:0]});
    end

    // R6: a write started by cs1 falling last; bus goes off at once.
    drive(4'b1100, 11'd9, 8'h99);
    @(negedge clk);
    drive(4'b0100, 11'd9, 8'h99);
    @(negedge clk);
    check(6, {dout_en, 8'h00}, {1'b0, 8'h00});
    drive(4'b0101, 11'd9, 8'h00);
    @(negedge clk);
    check(9, {dout_en, dout}, {1'b1, 8'h99}); // R9 commit and read same edge

    // R1: reset again returns the bus off.
    rst_n = 1'b0;
    @(negedge clk);
    check(1, {dout_en, 8'h00}, {1'b0, 8'h00});
    rst_n = 1'b1;
    @(negedge clk);
    check(1, {dout_en, dout}, {1'b1, 8'h99}); // R1 read sampled after release

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule